// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Sequencer

The sequencer turns one CPU data access into the series of external bus cycles that a 16-bit memory data bus needs. The CPU side presents an operand of 8, 16 or 32 bits together with a start address, a direction flag and write data. The memory behind the selected address area is either 8 or 16 bits wide, set by that area's control register. The block issues one bus cycle per clock. For each cycle it produces the address, marks which byte lanes carry data, drives write bytes onto those lanes, and collects read bytes into their operand positions.

The byte placement follows address parity. On a 16-bit bus, a byte whose address is even uses the low lane and a byte whose address is odd uses the high lane. An operand therefore needs as many cycles as the aligned 16-bit words it touches, so an odd 32-bit access takes three cycles. On an 8-bit bus every byte crosses the low lane, one byte per cycle, least significant byte first. A single-cycle done pulse closes each access. Address decoding, wait states and strobe timing are left to the surrounding logic: the one-hot area select arrives already decoded.

Top module: `bus_size_seq`

## Requirements
- R1: Reset leaves no access in progress, with busy_o, done_o, mem_cyc_o and mem_wstb_o all low. After reset only area 2 is enabled, and every area's width bit is 0.
- R2: An area register write updates only the bits whose cfg_mask_i bit is 1. Bit 7 is the enable bit (1 = enabled). Bit 3 is the width bit (1 = 8-bit memory, 0 = 16-bit memory). Every other bit is ignored.
- R3: If the selected area is disabled, or no area is selected, the access uses a 16-bit bus.
- R4: On an 8-bit bus, an operand of N bytes (size_i 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes) at address A takes N cycles. Cycle k uses address A+k and lane 0 only (bits 7:0), and carries operand byte k.
- R5: On a 16-bit bus, a 1-byte access takes one cycle at A. It uses lane 0 if A is even and lane 1 (bits 15:8) if A is odd.
- R6: On a 16-bit bus, a 2-byte access at even A takes one cycle, with byte 0 on lane 0 and byte 1 on lane 1. At odd A it takes two cycles: A with byte 0 on lane 1, then A+1 with byte 1 on lane 0.
- R7: On a 16-bit bus, a 4-byte access at even A takes two cycles: A with bytes 0/1 on lanes 0/1, then A+2 with bytes 2/3. At odd A it takes three cycles: A with byte 0 on lane 1, then A+1 with byte 1 on lane 0 and byte 2 on lane 1, then A+3 with byte 3 on lane 0.
- R8: A lane not used in a cycle has its write strobe low and its output byte at zero, and its read input is ignored. Reads raise no write strobe.
- R9: When done_o is high, rdata_o holds the operand read, with byte k taken from address A+k. Bytes above the operand size read as zero, and after a write rdata_o is zero.
- R10: A request is taken only while busy_o is low. Bus cycles start on the next clock and run back to back. done_o is a one-cycle pulse in the cycle after the last bus cycle, with busy_o low in that cycle. Requests raised while busy_o is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Area register write |
| cfg_idx_i | input | IW | Area register index |
| cfg_mask_i | input | 8 | Bit mask for the register write |
| cfg_data_i | input | 8 | Register write data |
| area_sel_i | input | NAREA | One-hot decoded area of the access |
| req_i | input | 1 | Access request |
| size_i | input | 2 | Operand size code |
| addr_i | input | AW | Operand start address |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write operand |
| busy_o | output | 1 | Access in progress, request not taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read operand |
| mem_cyc_o | output | 1 | External bus cycle active |
| mem_we_o | output | 1 | Active cycle is a write |
| mem_addr_o | output | AW | Bus cycle address |
| mem_lane_o | output | 2 | Byte lanes carrying data this cycle |
| mem_wstb_o | output | 2 | Per-lane write strobe and output enable |
| mem_dout_o | output | 16 | Write data per lane |
| mem_din_i | input | 16 | Read data per lane |

## Verification
The bench covers both bus widths, all three sizes, both address parities and both directions. It targets three cases in particular: the odd 32-bit split, the odd 16-bit split and the parity-based lane choice for single bytes. A wrong second-cycle address (A+2 in place of A+1, or A+2 in place of A+3) or a byte routed to the wrong lane would corrupt neighbouring memory, and the per-cycle address and lane checks would flag it. The unused lane of every read carries a neighbour's byte or filler on purpose, so a design that captured it would show non-zero upper bytes or wrong data in rdata_o. The configuration sequence writes each of the width and enable bits alone, which exposes a wrong reset enable value, a wrong default for a disabled area, and a write that disturbs unmasked bits.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int unsigned OP_BYTES = 4;
  localparam int unsigned LANES    = 2;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned BW_BIT   = 3;

  function automatic logic [2:0] op_bytes(input logic [1:0] sz);
    return sz[1] ? 3'd4 : (sz[0] ? 3'd2 : 3'd1);
  endfunction
endpackage

// File: rtl/bsz_area_regs.sv
module bsz_area_regs #(
  parameter int unsigned NAREA = 4,
  parameter logic [NAREA-1:0] RST_EN = NAREA'(4),
  localparam int unsigned IW = (NAREA > 1) ? $clog2(NAREA) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [7:0]       mask_i,
  input  logic [7:0]       data_i,
  input  logic [NAREA-1:0] sel_i,
  output logic             narrow_o
);
  import bsz_pkg::*;

  logic [NAREA-1:0] en_q, nar_q;
  logic cfg_unused;
  assign cfg_unused = ^{mask_i[6:4], mask_i[2:0], data_i[6:4], data_i[2:0]};

  for (genvar a = 0; a < NAREA; a++) begin : g_area
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[a]  <= RST_EN[a];
        nar_q[a] <= 1'b0;
      end else if (we_i && idx_i == IW'(a)) begin
        if (mask_i[EN_BIT]) en_q[a]  <= data_i[EN_BIT];
        if (mask_i[BW_BIT]) nar_q[a] <= data_i[BW_BIT];
      end
    end
  end

  // disabled or unselected area falls back to 16-bit
  assign narrow_o = |(sel_i & en_q & nar_q);
endmodule

// File: rtl/bsz_step_decode.sv
module bsz_step_decode
  import bsz_pkg::*;
(
  input  logic                  narrow_i,
  input  logic [1:0]            size_i,
  input  logic                  odd_i,
  input  logic [1:0]            step_i,
  output logic                  last_o,
  output logic [1:0]            off_o,
  output logic [LANES-1:0]      lane_o,
  output logic [LANES-1:0][1:0] bidx_o
);
  logic [2:0] nb;
  assign nb = op_bytes(size_i);

  // byte index carried by each lane on a 16-bit bus: 2*step + lane - odd
  logic [3:0]       ix  [LANES];
  logic [LANES-1:0] hit;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ix[g]  = {1'b0, step_i, 1'b0} + 4'(g) - {3'b0, odd_i};
    assign hit[g] = ix[g] < {1'b0, nb};
  end

  always_comb begin
    last_o = 1'b0;
    off_o  = 2'd0;
    lane_o = '0;
    bidx_o = '0;
    if (narrow_i) begin
      last_o    = ({1'b0, step_i} == nb - 3'd1);
      off_o     = step_i;
      lane_o[0] = 1'b1;
      bidx_o[0] = step_i;
    end else begin
      last_o = ({1'b0, step_i} == (({2'b0, odd_i} + nb - 3'd1) >> 1));
      off_o  = (step_i == 2'd0) ? 2'd0 : 2'({step_i, 1'b0} - {2'b0, odd_i});
      for (int l = 0; l < LANES; l++) begin
        lane_o[l] = hit[l];
        bidx_o[l] = hit[l] ? ix[l][1:0] : 2'd0;
      end
    end
  end
endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
  import bsz_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cap_i,
  input  logic                  wr_i,
  input  logic [LANES-1:0]      lane_i,
  input  logic [LANES-1:0][1:0] bidx_i,
  input  logic [31:0]           wdata_i,
  input  logic [15:0]           din_i,
  output logic [LANES-1:0]      wstb_o,
  output logic [15:0]           dout_o,
  output logic [31:0]           rdata_o
);
  logic [OP_BYTES-1:0][7:0] wd, rbuf_q;
  assign wd      = wdata_i;
  assign rdata_o = rbuf_q;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign wstb_o[g]        = wr_i & lane_i[g];
    assign dout_o[8*g +: 8] = wstb_o[g] ? wd[bidx_i[g]] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rbuf_q <= '0;
    else if (clr_i) rbuf_q <= '0;
    else if (cap_i) begin
      for (int l = 0; l < LANES; l++)
        if (lane_i[l]) rbuf_q[bidx_i[l]] <= din_i[8*l +: 8];
    end
  end
endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
  import bsz_pkg::*;
#(
  parameter int unsigned NAREA = 4,
  parameter int unsigned AW    = 24,
  parameter logic [NAREA-1:0] RST_EN = NAREA'(4),
  localparam int unsigned IW = (NAREA > 1) ? $clog2(NAREA) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic [7:0]       cfg_mask_i,
  input  logic [7:0]       cfg_data_i,
  input  logic [NAREA-1:0] area_sel_i,
  input  logic             req_i,
  input  logic [1:0]       size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      rdata_o,
  output logic             mem_cyc_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [1:0]       mem_lane_o,
  output logic [1:0]       mem_wstb_o,
  output logic [15:0]      mem_dout_o,
  input  logic [15:0]      mem_din_i
);
  logic                  busy_q, done_q, we_q, narrow_q, narrow_sel;
  logic [1:0]            size_q, step_q, off;
  logic [AW-1:0]         addr_q;
  logic [31:0]           wdata_q;
  logic                  last, accept;
  logic [LANES-1:0]      lane, lane_act;
  logic [LANES-1:0][1:0] bidx;

  bsz_area_regs #(.NAREA(NAREA), .RST_EN(RST_EN)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .idx_i(cfg_idx_i), .mask_i(cfg_mask_i),
    .data_i(cfg_data_i), .sel_i(area_sel_i), .narrow_o(narrow_sel)
  );

  bsz_step_decode u_dec (
    .narrow_i(narrow_q), .size_i(size_q), .odd_i(addr_q[0]), .step_i(step_q),
    .last_o(last), .off_o(off), .lane_o(lane), .bidx_o(bidx)
  );

  assign accept   = req_i & ~busy_q;
  assign lane_act = busy_q ? lane : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      we_q     <= 1'b0;
      narrow_q <= 1'b0;
      size_q   <= 2'd0;
      step_q   <= 2'd0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      done_q <= busy_q & last;
      if (accept) begin
        busy_q   <= 1'b1;
        step_q   <= 2'd0;
        we_q     <= we_i;
        narrow_q <= narrow_sel;
        size_q   <= size_i;
        addr_q   <= addr_i;
        wdata_q  <= wdata_i;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      step_q <= step_q + 2'd1;
      end
    end
  end

  bsz_lane_steer u_steer (
    .clk_i, .rst_ni, .clr_i(accept), .cap_i(busy_q & ~we_q), .wr_i(busy_q & we_q),
    .lane_i(lane_act), .bidx_i(bidx), .wdata_i(wdata_q), .din_i(mem_din_i),
    .wstb_o(mem_wstb_o), .dout_o(mem_dout_o), .rdata_o(rdata_o)
  );

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign mem_cyc_o  = busy_q;
  assign mem_we_o   = busy_q & we_q;
  assign mem_addr_o = busy_q ? addr_q + AW'(off) : '0;
  assign mem_lane_o = lane_act;
endmodule

// File: rtl/bsz_seq_chk.sv
module bsz_seq_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_cyc_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_wstb_o,
  input logic [15:0]   mem_dout_o
);
  logic [2:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 3'd0;
    else if (!mem_cyc_o) run_q <= 3'd0;
    else if (run_q != 3'd7) run_q <= run_q + 3'd1;
  end

  // R10
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_after_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_cyc_o) && !mem_cyc_o && !busy_o));
  a_r10_max_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 3'd4);
  // R7
  a_r7_addr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cyc_o && $past(mem_cyc_o)) |-> (mem_addr_o > $past(mem_addr_o)));
  // R8
  a_r8_wstb_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_wstb_o) |-> (mem_cyc_o && mem_we_o));
  a_r8_idle_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wstb_o[0] |-> mem_dout_o[7:0] == 8'h00) and (!mem_wstb_o[1] |-> mem_dout_o[15:8] == 8'h00));
endmodule

bind bus_size_seq bsz_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/bus_size_seq_bench.sv
module bus_size_seq_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 24;
  localparam int unsigned NAREA = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_mask = '0, cfg_data = '0;
  logic [NAREA-1:0] area_sel = '0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] size = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic busy, done, mem_cyc, mem_we;
  logic [31:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_lane, mem_wstb;
  logic [15:0] mem_dout, mem_din;
  logic w8_mode = 1'b0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_size_seq #(.NAREA(NAREA), .AW(AW)) u_bus_size_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_mask_i(cfg_mask), .cfg_data_i(cfg_data), .area_sel_i(area_sel),
    .req_i(req), .size_i(size), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .mem_cyc_o(mem_cyc),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_lane_o(mem_lane),
    .mem_wstb_o(mem_wstb), .mem_dout_o(mem_dout), .mem_din_i(mem_din)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h3C;
  endfunction

  // memory model: unused lane carries neighbour byte or filler
  always_comb begin
    if (w8_mode) mem_din = {8'hEE, pat(mem_addr)};
    else mem_din = {pat({mem_addr[AW-1:1], 1'b1}), pat({mem_addr[AW-1:1], 1'b0})};
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] idx, input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_mask = m; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit w8, input logic [NAREA-1:0] sel, input logic [1:0] sz,
                        input logic [AW-1:0] a, input bit wr, input logic [31:0] wd,
                        input bit hold, input string rq);
    int n, steps;
    logic [AW-1:0] ea [4];
    logic [1:0] el [4];
    logic [15:0] ed [4];
    logic [31:0] er;
    n = (sz == 2'd2) ? 4 : ((sz == 2'd1) ? 2 : 1);
    for (int k = 0; k < 4; k++) begin ea[k] = '0; el[k] = '0; ed[k] = '0; end
    if (w8) begin
      steps = n;
      for (int i = 0; i < n; i++) begin
        ea[i] = a + AW'(i); el[i] = 2'b01;
        if (wr) ed[i] = {8'h00, wd[8*i +: 8]};
      end
    end else begin
      steps = ((int'(a[0]) + n - 1) >> 1) + 1;
      for (int i = 0; i < n; i++) begin
        int k, ln;
        k  = (int'(a[0]) + i) >> 1;
        ln = int'(a[0]) ^ (i & 1);
        if (el[k] == 2'b00) ea[k] = a + AW'(i);
        el[k][ln] = 1'b1;
        if (wr) ed[k][8*ln +: 8] = wd[8*i +: 8];
      end
    end
    er = '0;
    if (!wr) for (int i = 0; i < n; i++) er[8*i +: 8] = pat(a + AW'(i));

    @(negedge clk);
    w8_mode = w8; area_sel = sel; req = 1'b1; size = sz; addr = a; we = wr; wdata = wd;
    @(negedge clk);
    if (hold) begin addr = a + AW'(64); size = 2'd2; we = ~wr; end
    else req = 1'b0;
    for (int k = 0; k < steps; k++) begin
      chk(rq, $sformatf("cyc/busy/done step%0d", k), {61'd0, mem_cyc, busy, done}, 64'b110);
      chk(rq, $sformatf("addr step%0d", k), 64'(mem_addr), 64'(ea[k]));
      chk(rq, $sformatf("lane step%0d", k), 64'(mem_lane), 64'(el[k]));
      chk("R8", $sformatf("wstb step%0d", k), 64'(mem_wstb), wr ? 64'(el[k]) : 64'd0);
      chk("R8", $sformatf("dout step%0d", k), 64'(mem_dout), 64'(ed[k]));
      @(negedge clk);
    end
    req = 1'b0;
    chk("R10", "done cycle cyc/busy/done", {61'd0, mem_cyc, busy, done}, 64'b001);
    chk("R9", "rdata at done", 64'(rdata), 64'(er));
    if (hold) begin
      @(negedge clk);
      chk("R10", "request while busy dropped", {62'd0, mem_cyc, busy}, 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset idle", {60'd0, busy, done, mem_cyc, |mem_wstb}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {60'd0, busy, done, mem_cyc, |mem_wstb}, 64'd0);

    // R1: area 2 enabled, width 0 after reset
    access(1'b0, 4'b0100, 2'd2, 24'h000100, 1'b0, 32'h0, 1'b0, "R1");
    cfg(2'd2, 8'h08, 8'h08);
    access(1'b1, 4'b0100, 2'd1, 24'h000201, 1'b0, 32'h0, 1'b0, "R1");
    // R3: area 0 disabled from reset, width bit alone has no effect
    cfg(2'd0, 8'h08, 8'h08);
    access(1'b0, 4'b0001, 2'd1, 24'h000305, 1'b0, 32'h0, 1'b0, "R3");
    // R2: enable bit alone, then unrelated bits
    cfg(2'd0, 8'h80, 8'h80);
    access(1'b1, 4'b0001, 2'd1, 24'h000305, 1'b1, 32'h0000BEEF, 1'b0, "R2");
    cfg(2'd0, 8'h77, 8'h00);
    access(1'b1, 4'b0001, 2'd0, 24'h000402, 1'b0, 32'h0, 1'b0, "R2");
    // R3: no area selected
    access(1'b0, 4'b0000, 2'd2, 24'h000503, 1'b0, 32'h0, 1'b0, "R3");
    // R2: width bit back to 16-bit
    cfg(2'd0, 8'h08, 8'h00);
    access(1'b0, 4'b0001, 2'd2, 24'h000601, 1'b1, 32'h11223344, 1'b0, "R2");

    // sweep on area 1
    for (int w = 0; w < 2; w++) begin
      cfg(2'd1, 8'hFF, (w != 0) ? 8'h88 : 8'h80);
      for (int sz = 0; sz < 3; sz++)
        for (int od = 0; od < 2; od++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [AW-1:0] a;
            logic [31:0] wd;
            string rq;
            a  = 24'h0A1240 + AW'(sz * 8 + od + wr * 16 + w * 48);
            wd = 32'hC3A51E00 ^ {a[7:0], a[7:0], a[15:8], 8'(sz * 17 + od)};
            if (w != 0) rq = "R4";
            else if (sz == 0) rq = "R5";
            else if (sz == 1) rq = "R6";
            else rq = "R7";
            access(w != 0, 4'b0010, 2'(sz), a, wr != 0, wd,
                   (sz == 2 && od == 1 && wr == 1), rq);
          end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule